// File: doc/BRIEF.md
# Configuration Record Checksum Checker

This block checks the integrity of a configuration record as it streams past, one byte per clock with a valid strobe. A start strobe opens a record. The byte at a fixed index gives the record's length in bytes. The byte at another fixed index holds the stored checksum. The block adds every byte of the record modulo 256, the stored checksum byte included. It then takes the stored checksum back out of that sum and inverts the result bit by bit. The record is good when this computed checksum equals the stored one.

A verdict pulse follows the last byte of the record. It carries the match flag and the computed checksum. When a record is opened with the adjust flag set, the verdict also marks the computed checksum as the replacement value to write back, so that a record can be regenerated. Bytes outside an open record are dropped. This includes bytes before the first start, bytes after the record's end, and bytes with the valid strobe low.

Top module: `cfg_record_checksum`

## Requirements
- R1: After reset, `done`, `match` and `fix_valid` are low and `csum_out` is 0, and the block ignores every byte until the first `start`.
- R2: The sum is the modulo-256 total of the first N valid bytes after `start`, counting from index 0. N is the value of the byte at index 2 (parameter `LEN_POS`).
- R3: The computed checksum is the bitwise inverse of (sum minus stored byte). The stored byte is the one at index 1 (parameter `CSUM_POS`). During the `done` cycle the computed checksum appears on `csum_out`, and `csum_out` is 0 in every other cycle.
- R4: `match` is high only in the `done` cycle, and only when the computed checksum equals the stored byte.
- R5: `done` is high for exactly one cycle: the cycle after the clock edge that accepts byte N-1.
- R6: A length value below 3 ends the record at index 2, so the record always contains both fixed-position bytes.
- R7: Cycles with `in_valid` low do not count. Bytes after the record's last byte are ignored until the next `start`.
- R8: `start` clears the sum, the count and the latched length. A byte presented in the same cycle as `start` is discarded. A `start` in the middle of a record abandons that record with no `done`.
- R9: `adjust_en` is sampled with `start`. For a record opened with it high, `fix_valid` is high together with `done`, and `fix_valid` is never high otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Opens a new record and clears all state |
| adjust_en | input | 1 | Regeneration request, sampled with `start` |
| in_valid | input | 1 | `in_byte` carries a record byte this cycle |
| in_byte | input | 8 | Record byte |
| done | output | 1 | One-cycle verdict pulse after the last byte |
| match | output | 1 | Computed checksum equals stored byte (with `done`) |
| fix_valid | output | 1 | `csum_out` is the replacement checksum (with `done`, adjust mode) |
| csum_out | output | 8 | Computed checksum during `done`, otherwise 0 |

## Verification
All results are due one cycle after the edge that accepts the record's last byte. In that cycle the verdict, match, checksum and replacement flag appear together, and in the next cycle they are all back to idle. The bench drives each byte half a cycle before an edge and samples on the following falling edge. The falling edge right after the last byte is therefore the verdict cycle. Every other sampled cycle of the record, including gap cycles and trailing bytes, must show `done` low.

// File: rtl/cfgsum_pkg.sv
// Package: shared byte type and the effective-length rule of the record.
// Assumes the record length field is one byte wide.
package cfgsum_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    // Clamp a raw length value so the record covers both fixed fields.
    function automatic byte_t eff_len(input byte_t raw, input byte_t floor_len);
        return (raw < floor_len) ? floor_len : raw;
    endfunction

endpackage

// File: rtl/cfgsum_tracker.sv
// Module: tracks the position inside the record, latches the length byte and
// flags the final byte. Assumes LEN_POS is below 255 and that the length
// field is clamped to FLOOR_LEN.
module cfgsum_tracker
    import cfgsum_pkg::*;
#(
    parameter int    LEN_POS   = 2,
    parameter byte_t FLOOR_LEN = 8'd3
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start,
    input  logic  in_valid,
    input  byte_t in_byte,
    output logic  accept,
    output byte_t idx,
    output logic  last_beat
);

    localparam byte_t LEN_IDX = byte_t'(LEN_POS);

    logic  active_q;
    byte_t cnt_q;
    byte_t len_q;
    byte_t bound;
    logic  at_len;
    logic  past_len;

    // Decide whether this beat is accepted and whether it closes the record.
    always_comb begin
        accept    = active_q & in_valid & ~start;
        at_len    = (cnt_q == LEN_IDX);
        past_len  = (cnt_q > LEN_IDX);
        bound     = at_len ? eff_len(in_byte, FLOOR_LEN) : len_q;
        last_beat = accept & (at_len | past_len) & (cnt_q == byte_t'(bound - byte_t'(1)));
        idx       = cnt_q;
    end

    // Advance position, capture the length, close the record on its last byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            len_q    <= FLOOR_LEN;
        end else if (start) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
            len_q    <= FLOOR_LEN;
        end else if (accept) begin
            cnt_q <= cnt_q + byte_t'(1);
            if (at_len) begin
                len_q <= eff_len(in_byte, FLOOR_LEN);
            end
            if (last_beat) begin
                active_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/cfgsum_accum.sv
// Module: modulo-256 accumulator and capture register for the stored checksum.
// Assumes accept is only high for bytes that belong to the open record.
module cfgsum_accum
    import cfgsum_pkg::*;
#(
    parameter int CSUM_POS = 1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start,
    input  logic  accept,
    input  byte_t idx,
    input  byte_t in_byte,
    output byte_t sum_o,
    output byte_t stored_o
);

    localparam byte_t CSUM_IDX = byte_t'(CSUM_POS);

    byte_t sum_q;
    byte_t stored_q;

    // Add every accepted byte; the checksum byte is added like any other.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            sum_q <= '0;
        end else if (accept) begin
            sum_q <= sum_q + in_byte;
        end
    end

    // Keep a copy of the byte at the checksum index.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            stored_q <= '0;
        end else if (accept && (idx == CSUM_IDX)) begin
            stored_q <= in_byte;
        end
    end

    assign sum_o    = sum_q;
    assign stored_o = stored_q;

endmodule

// File: rtl/cfgsum_verdict.sv
// Module: forms the computed checksum and the one-cycle verdict outputs.
// Assumes sum_i and stored_i are stable in the cycle after the last byte.
module cfgsum_verdict
    import cfgsum_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start,
    input  logic  adjust_en,
    input  logic  last_beat,
    input  byte_t sum_i,
    input  byte_t stored_i,
    output logic  done,
    output logic  match,
    output logic  fix_valid,
    output byte_t csum_out
);

    logic  done_q;
    logic  adj_q;
    byte_t computed;

    // Register the end-of-record flag into the verdict pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= last_beat;
        end
    end

    // Hold the regeneration request for the record opened by start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adj_q <= 1'b0;
        end else if (start) begin
            adj_q <= adjust_en;
        end
    end

    // Remove the stored byte from the sum, invert, and compare.
    always_comb begin
        computed  = ~byte_t'(sum_i - stored_i);
        done      = done_q;
        match     = done_q & (computed == stored_i);
        fix_valid = done_q & adj_q;
        csum_out  = done_q ? computed : '0;
    end

endmodule

// File: rtl/cfg_record_checksum.sv
// Module: top of the streaming configuration-record checksum checker.
// Assumes LEN_POS and CSUM_POS are distinct indices below 255.
module cfg_record_checksum
    import cfgsum_pkg::*;
#(
    parameter int LEN_POS  = 2,
    parameter int CSUM_POS = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       adjust_en,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    output logic       done,
    output logic       match,
    output logic       fix_valid,
    output logic [7:0] csum_out
);

    localparam int    LAST_FIXED = (LEN_POS > CSUM_POS) ? LEN_POS : CSUM_POS;
    localparam byte_t FLOOR_LEN  = byte_t'(LAST_FIXED + 1);

    logic  accept;
    logic  last_beat;
    byte_t idx;
    byte_t sum_w;
    byte_t stored_w;

    cfgsum_tracker #(
        .LEN_POS   (LEN_POS),
        .FLOOR_LEN (FLOOR_LEN)
    ) i_tracker (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .in_valid  (in_valid),
        .in_byte   (in_byte),
        .accept    (accept),
        .idx       (idx),
        .last_beat (last_beat)
    );

    cfgsum_accum #(
        .CSUM_POS (CSUM_POS)
    ) i_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .accept   (accept),
        .idx      (idx),
        .in_byte  (in_byte),
        .sum_o    (sum_w),
        .stored_o (stored_w)
    );

    cfgsum_verdict i_verdict (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .adjust_en (adjust_en),
        .last_beat (last_beat),
        .sum_i     (sum_w),
        .stored_i  (stored_w),
        .done      (done),
        .match     (match),
        .fix_valid (fix_valid),
        .csum_out  (csum_out)
    );

endmodule

// File: rtl/cfgsum_checker.sv
// Module: temporal properties of the checksum checker's ports, bound to the top.
module cfgsum_checker (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic in_valid,
    input logic done,
    input logic match,
    input logic fix_valid
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!done && !fix_valid));

    assert_match_needs_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> done);

    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(in_valid) && !$past(start)));

    assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !done);

    assert_fix_needs_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fix_valid |-> done);

endmodule

bind cfg_record_checksum cfgsum_checker i_cfgsum_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .in_valid  (in_valid),
    .done      (done),
    .match     (match),
    .fix_valid (fix_valid)
);

// File: tb/test_cfg_record_checksum.sv
`timescale 1ns/1ps
module test_cfg_record_checksum;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start;
    logic       adjust_en;
    logic       in_valid;
    logic [7:0] in_byte;
    logic       done;
    logic       match;
    logic       fix_valid;
    logic [7:0] csum_out;

    int n_run  = 0;
    int n_fail = 0;

    logic [7:0] rec [0:299];

    always #4 clk = ~clk;

    cfg_record_checksum i_cfg_record_checksum (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .adjust_en (adjust_en),
        .in_valid  (in_valid),
        .in_byte   (in_byte),
        .done      (done),
        .match     (match),
        .fix_valid (fix_valid),
        .csum_out  (csum_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Effective record length per R2/R6 (defaults: length at 2, floor 3).
    function automatic int rec_len();
        return (rec[2] < 8'd3) ? 3 : int'(rec[2]);
    endfunction

    // Expected checksum per R3.
    function automatic logic [7:0] model_csum();
        logic [7:0] s = 8'd0;
        for (int i = 0; i < rec_len(); i++) s = s + rec[i];
        return ~(s - rec[1]);
    endfunction

    // Build a record; good records carry a correct checksum byte.
    task automatic make_record(input int len, input bit good);
        logic [7:0] s;
        for (int i = 0; i < 300; i++) rec[i] = 8'($urandom);
        rec[2] = 8'(len);
        if (good) begin
            s = 8'd0;
            for (int i = 0; i < rec_len(); i++) if (i != 1) s = s + rec[i];
            rec[1] = ~s;
        end
    endtask

    // Open a record and stream n_send bytes, checking each sampled cycle.
    task automatic send_record(input int n_send, input bit adj, input bit junk_start,
                               input int max_gap, input bit expect_done);
        int n = rec_len();
        logic [7:0] exp_c = model_csum();
        @(negedge clk);
        start = 1'b1; adjust_en = adj; in_valid = junk_start; in_byte = 8'($urandom);
        @(negedge clk);
        start = 1'b0; adjust_en = 1'($urandom); in_valid = 1'b0;
        for (int i = 0; i < n_send; i++) begin
            int g = (max_gap > 0) ? int'($urandom_range(0, max_gap)) : 0;
            for (int k = 0; k < g; k++) begin
                in_valid = 1'b0; in_byte = 8'($urandom);
                @(negedge clk);
                chk("R7 gap cycle done", done, 0);
            end
            in_valid = 1'b1; in_byte = rec[i];
            @(negedge clk);
            if (expect_done && i == n - 1) begin
                chk("R5 done after last byte", done, 1);
                chk("R3 csum_out", csum_out, exp_c);
                chk("R4 match", match, (exp_c == rec[1]) ? 1 : 0);
                chk("R9 fix_valid", fix_valid, adj);
            end else begin
                chk("R7 done low mid/after record", done, 0);
                chk("R3 csum_out idle", csum_out, 0);
            end
        end
        in_valid = 1'b0;
        @(negedge clk);
        chk("R5 done single cycle", done, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        rst_n = 1'b0; start = 1'b0; adjust_en = 1'b0; in_valid = 1'b0; in_byte = 8'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset done", done, 0);
        chk("R1 reset match", match, 0);
        chk("R1 reset fix_valid", fix_valid, 0);
        chk("R1 reset csum_out", csum_out, 0);

        // R1: bytes before the first start are ignored.
        for (int i = 0; i < 8; i++) begin
            in_valid = 1'b1; in_byte = (i == 2) ? 8'd3 : 8'($urandom);
            @(negedge clk);
            chk("R1 no start no done", done, 0);
        end
        in_valid = 1'b0;

        // R2/R4: plain good and bad records.
        make_record(10, 1'b1); send_record(10, 1'b0, 1'b0, 0, 1'b1);
        make_record(10, 1'b0); rec[1] = model_csum() ^ 8'h5a; send_record(10, 1'b0, 1'b0, 0, 1'b1);
        // R6: short length values clamp to 3.
        make_record(0, 1'b1); send_record(3, 1'b0, 1'b0, 0, 1'b1);
        make_record(1, 1'b0); send_record(3, 1'b1, 1'b0, 0, 1'b1);
        make_record(2, 1'b1); send_record(3, 1'b0, 1'b0, 1, 1'b1);
        make_record(3, 1'b1); send_record(3, 1'b1, 1'b0, 0, 1'b1);
        // R2: longest record.
        make_record(255, 1'b1); send_record(255, 1'b0, 1'b0, 0, 1'b1);
        // R7: trailing bytes and gaps are ignored.
        make_record(12, 1'b1); send_record(18, 1'b0, 1'b0, 2, 1'b1);
        // R8: start-cycle byte discarded; mid-record start abandons.
        make_record(9, 1'b1); send_record(9, 1'b1, 1'b1, 0, 1'b1);
        make_record(20, 1'b1); send_record(6, 1'b1, 1'b0, 0, 1'b0);
        make_record(7, 1'b1); send_record(7, 1'b0, 1'b1, 1, 1'b1);

        // Random records.
        for (int r = 0; r < 30; r++) begin
            make_record(int'($urandom_range(0, 60)), 1'($urandom));
            send_record(rec_len() + int'($urandom_range(0, 3)), 1'($urandom),
                        1'($urandom), 2, 1'b1);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule